// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a word-wide main-memory port. Each line keeps a valid flag, a dirty flag, a tag and a group of data words. A processor address is cut into three fields: the low bits are the byte offset, the bits above them select a word in the line, the next bits pick the line (the block address modulo the number of lines) and the top bits form the tag. With the defaults (16-bit addresses, 16 lines of four 32-bit words), word select is bits [3:2], the line index is bits [7:4] and the tag is bits [15:8]. For example, 0x483C maps to tag 0x48, line 3, word 3.

A lookup takes a single cycle. On a hit, a read returns the stored word and a write updates only the cached word and marks the line dirty. On a miss, the cache raises busy and runs a small state machine. If the indexed line is valid and dirty, every word of it is first written to memory under its old tag. Then every word of the new line is read in, even if only one word is needed. Finally the pending access is applied to the refilled line.

The memory port moves one word per request/acknowledge transfer. The processor must not present new work while busy is high; a request made then is ignored.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset, `cpu_busy`, `cpu_done` and `mem_req` are 0 and every line is invalid, so the first access to any address is a miss.
- R2: Address fields are byte offset [1:0], word select [3:2], line index [7:4] and tag [15:8]. Every line transfer on the memory port visits words 0,1,2,3 in that order at `{tag, index, word, 2'b00}`. Processor addresses must be word aligned.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. A read hit returns the addressed word of that line and causes no memory transfer.
- R4: A write hit updates only the addressed cached word and sets the line dirty. No memory write takes place at that time.
- R5: A miss on a valid dirty line first writes all four words of the old line to memory at the old tag's addresses, then reads all four words of the new line, then applies the access. Memory then holds the evicted data.
- R6: A miss on an invalid or clean line skips the write-back and performs exactly four memory reads. The whole line is filled, so the other words of that line hit afterwards.
- R7: A read miss leaves the refilled line clean, so evicting it later causes no memory writes.
- R8: A write miss merges the write word into the refilled line and sets the line dirty, so its later eviction writes the stored value back.
- R9: `cpu_busy` is 1 from the cycle after a missing request until the cycle its `cpu_done` pulses. A request presented while busy is ignored: it alters no data and produces no `cpu_done`.
- R10: For a hit, `cpu_done` is 1 in the cycle right after the accepting clock edge. Each accepted request gives exactly one `cpu_done` pulse, and a read's result is on `cpu_rdata` in that cycle.
- R11: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we` and `mem_addr` hold their values. Each `mem_ack` completes one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, accepted when busy is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load result, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Miss handling in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = refill word |
| mem_addr | output | 16 | Memory byte address of the word |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | 32 | Refill data, valid with mem_ack |

## Verification
Two things can fall in the same cycle while a miss is in progress: a new processor request and a write-back or refill transfer. To provoke this, the bench drives a store to a line that is resident while the cache is busy on a miss. It judges the result in two ways: no extra completion may appear on the scoreboard, and a later read of that word must still return its old value. The other overlap is a completion pulse and the next request in the same cycle. This is exercised by issuing requests as soon as busy drops, with the scoreboard checking that completions and returned data stay in order.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_APPLY
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_dirty,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int WOFF_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - WOFF_W - IDX_W;
  localparam int DAT_AW = IDX_W + WOFF_W;
  localparam logic [WOFF_W-1:0] LAST_W = WOFF_W'(WORDS - 1);

  // address split of the incoming request
  logic [WOFF_W-1:0] c_word;
  logic [IDX_W-1:0]  c_idx;
  logic [TAG_W-1:0]  c_tag;
  assign c_word = cpu_addr[OFF_W +: WOFF_W];
  assign c_idx  = cpu_addr[OFF_W + WOFF_W +: IDX_W];
  assign c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

  dmc_state_e        state;
  logic              r_we;
  logic [WOFF_W-1:0] r_word;
  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [TAG_W-1:0]  r_old_tag;
  logic [DATA_W-1:0] r_wdata;
  logic [WOFF_W-1:0] cnt;

  logic              t_valid, t_dirty;
  logic [TAG_W-1:0]  t_tag;
  logic              t_wr_en, t_wr_dirty;
  logic [IDX_W-1:0]  t_rd_idx, t_wr_idx;
  logic [TAG_W-1:0]  t_wr_tag;

  logic [DAT_AW-1:0] d_rd_addr, d_wr_addr;
  logic [DATA_W-1:0] d_rd, d_wr_data;
  logic              d_wr_en;

  logic accept, hit;
  assign accept   = (state == ST_IDLE) && cpu_req;
  assign t_rd_idx = (state == ST_IDLE) ? c_idx : r_idx;
  assign hit      = t_valid && (t_tag == c_tag);

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (t_rd_idx),
    .rd_valid (t_valid),
    .rd_dirty (t_dirty),
    .rd_tag   (t_tag),
    .wr_en    (t_wr_en),
    .wr_idx   (t_wr_idx),
    .wr_dirty (t_wr_dirty),
    .wr_tag   (t_wr_tag)
  );

  dmc_data_store #(.DEPTH(LINES * WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_addr (d_rd_addr),
    .rd_data (d_rd),
    .wr_en   (d_wr_en),
    .wr_addr (d_wr_addr),
    .wr_data (d_wr_data)
  );

  // metadata write: write hit in idle, final update when applying a miss
  always_comb begin
    t_wr_en    = 1'b0;
    t_wr_idx   = r_idx;
    t_wr_dirty = r_we;
    t_wr_tag   = r_tag;
    if (accept && hit && cpu_we) begin
      t_wr_en    = 1'b1;
      t_wr_idx   = c_idx;
      t_wr_dirty = 1'b1;
      t_wr_tag   = c_tag;
    end else if (state == ST_APPLY) begin
      t_wr_en = 1'b1;
    end
  end

  // data array port selection
  always_comb begin
    case (state)
      ST_IDLE:  d_rd_addr = {c_idx, c_word};
      ST_WBACK: d_rd_addr = {r_idx, cnt};
      default:  d_rd_addr = {r_idx, r_word};
    endcase
    d_wr_en   = 1'b0;
    d_wr_addr = {r_idx, r_word};
    d_wr_data = r_wdata;
    if (accept && hit && cpu_we) begin
      d_wr_en   = 1'b1;
      d_wr_addr = {c_idx, c_word};
      d_wr_data = cpu_wdata;
    end else if (state == ST_FILL && mem_ack) begin
      d_wr_en   = 1'b1;
      d_wr_addr = {r_idx, cnt};
      d_wr_data = mem_rdata;
    end else if (state == ST_APPLY && r_we) begin
      d_wr_en = 1'b1;
    end
  end

  // memory port driven from state registers only
  assign mem_req   = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = {(state == ST_WBACK) ? r_old_tag : r_tag, r_idx, cnt, {OFF_W{1'b0}}};
  assign mem_wdata = d_rd;
  assign cpu_busy  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      r_we      <= 1'b0;
      r_word    <= '0;
      r_idx     <= '0;
      r_tag     <= '0;
      r_old_tag <= '0;
      r_wdata   <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            if (hit) begin
              cpu_done <= 1'b1;
              if (!cpu_we) cpu_rdata <= d_rd;
            end else begin
              r_we      <= cpu_we;
              r_word    <= c_word;
              r_idx     <= c_idx;
              r_tag     <= c_tag;
              r_old_tag <= t_tag;
              r_wdata   <= cpu_wdata;
              cnt       <= '0;
              state     <= (t_valid && t_dirty) ? ST_WBACK : ST_FILL;
            end
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            cnt <= (cnt == LAST_W) ? '0 : cnt + 1'b1;
            if (cnt == LAST_W) state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            cnt <= (cnt == LAST_W) ? '0 : cnt + 1'b1;
            if (cnt == LAST_W) state <= ST_APPLY;
          end
        end
        default: begin
          cpu_done <= 1'b1;
          if (!r_we) cpu_rdata <= d_rd;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    accept |-> (cpu_addr[OFF_W-1:0] == '0)); // R2
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> (!mem_req && cpu_done)); // R3
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> (cpu_busy && !cpu_done)); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_busy); // R9
  AST_NO_WB_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> !(mem_req && mem_we)); // R5
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R11
endmodule

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_done, cpu_busy;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  dm_wb_cache u_dm_wb_cache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string lbl, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
    end
  endtask

  function automatic logic [31:0] init_val(input logic [13:0] w);
    return {2'b10, w ^ 14'h2A5C, 2'b01, w};
  endfunction

  // backing memory model
  logic [31:0] bmem [int];
  int wr_cnt = 0, rd_cnt = 0, addr_err = 0, wseq = 0, rseq = 0;
  logic [11:0] exp_wb_line = '0, exp_fill_line = '0;

  function automatic logic [31:0] bmem_rd(input logic [13:0] w);
    return bmem.exists(int'(w)) ? bmem[int'(w)] : init_val(w);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        bmem[int'(mem_addr[15:2])] = mem_wdata;
        if (mem_addr[15:4] != exp_wb_line || mem_addr[3:2] != wseq[1:0] || mem_addr[1:0] != 2'b00)
          addr_err++;
        wseq++;
        wr_cnt++;
      end else begin
        mem_rdata <= bmem_rd(mem_addr[15:2]);
        if (mem_addr[15:4] != exp_fill_line || mem_addr[3:2] != rseq[1:0] || mem_addr[1:0] != 2'b00)
          addr_err++;
        rseq++;
        rd_cnt++;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // reference model built from the requirements
  logic [31:0] ref_q [int];
  bit          sh_v [16];
  bit          sh_d [16];
  logic [7:0]  sh_t [16];

  function automatic logic [31:0] ref_rd(input logic [13:0] w);
    return ref_q.exists(int'(w)) ? ref_q[int'(w)] : init_val(w);
  endfunction

  typedef struct packed {
    logic        we;
    logic [31:0] exp;
  } sb_item_t;
  sb_item_t sbq[$];
  int done_seen = 0;

  // monitor: pops one item per completion
  always @(negedge clk) begin
    if (!rst && cpu_done) begin
      done_seen++;
      if (sbq.size() == 0) begin
        chk("R10 completion without request", 32'd1, 32'd0);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        if (!it.we) chk("R3 load data", cpu_rdata, it.exp);
      end
    end
  end

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] wd,
                        input bit poke, input string lbl);
    int idx = int'(a[7:4]);
    bit hit = sh_v[idx] && (sh_t[idx] == a[15:8]);
    bit dty = sh_v[idx] && sh_d[idx];
    int w0, r0, d0;
    sb_item_t it;
    it.we  = we;
    it.exp = ref_rd(a[15:2]);
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    exp_wb_line   = {sh_t[idx], a[7:4]};
    exp_fill_line = a[15:4];
    wseq = 0; rseq = 0;
    w0 = wr_cnt; r0 = rd_cnt; d0 = done_seen;
    sbq.push_back(it);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    if (hit) chk({"R10 hit done next cycle ", lbl}, {31'd0, cpu_done}, 32'd1);
    else     chk({"R9 busy after miss ", lbl}, {31'd0, cpu_busy}, 32'd1);
    if (poke && !hit) begin
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h4934; cpu_wdata = 32'hDEAD0000;
      @(negedge clk);
      cpu_req = 1'b0;
    end
    while (done_seen == d0) @(negedge clk);
    chk({"R5 write-back words ", lbl}, wr_cnt - w0, (hit || !dty) ? 0 : 4);
    chk({"R6 refill words ", lbl}, rd_cnt - r0, hit ? 0 : 4);
    if (we) ref_q[int'(a[15:2])] = wd;
    if (!hit) begin
      sh_v[idx] = 1'b1; sh_t[idx] = a[15:8]; sh_d[idx] = we;
    end else if (we) begin
      sh_d[idx] = 1'b1;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin sh_v[i] = 0; sh_d[i] = 0; sh_t[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, cpu_busy}, 32'd0);
    chk("R1 done after reset", {31'd0, cpu_done}, 32'd0);
    chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);

    access(1'b0, 16'h483C, '0, 0, "R1 cold read miss");   // word 3 of line 3
    access(1'b0, 16'h4838, '0, 0, "R6 other word hits");
    access(1'b1, 16'h483C, 32'h9, 0, "R4 write hit");
    chk("R4 memory untouched by write hit", bmem_rd(14'h120F), init_val(14'h120F));
    access(1'b0, 16'h483C, '0, 0, "R4 read back");
    access(1'b1, 16'h4938, 32'h1, 0, "R5 dirty write miss");
    chk("R5 victim word in memory", bmem_rd(14'h120F), 32'h9);
    access(1'b0, 16'h4938, '0, 0, "R8 merged write");
    access(1'b0, 16'h4930, '0, 0, "R6 refilled word");
    access(1'b0, 16'h1234, '0, 0, "R8 evict write-miss line");
    chk("R8 written word in memory", bmem_rd(14'h124E), 32'h1);
    access(1'b0, 16'h4938, '0, 0, "R7 clean evict");
    access(1'b1, 16'h5500, 32'h77, 1, "R9 poke while busy");
    access(1'b0, 16'h4934, '0, 0, "R9 poked word unchanged");

    for (int i = 0; i < 16; i++)
      access(1'b1, {8'h20, i[3:0], 4'h4}, 32'hA000 + i, 0, "R5 fill sweep");
    for (int i = 0; i < 16; i++)
      access(1'b0, {8'h21, i[3:0], 4'h4}, '0, 0, "R5 evict sweep");
    for (int i = 0; i < 16; i++)
      chk("R5 sweep write-back content", bmem_rd({8'h20, i[3:0], 2'd1}), 32'hA000 + i);
    access(1'b0, 16'h2054, '0, 0, "R3 tag mismatch misses");

    chk("R2 line transfer addresses", addr_err, 0);
    chk("R10 scoreboard drained", sbq.size(), 0);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule